// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the moment an external event happens, measured against a free-running 16-bit timer count. The event comes from one of two trigger lines: a dedicated capture pin, or the output of an analog comparator. The chosen line passes through a two-stage synchronizer. A digital filter can then be switched in; it accepts a new level only after four consecutive samples agree on it. An edge detector follows, and it fires on the polarity that software has chosen. On each detected edge the present timer count is copied into the capture register, the capture flag is set, and an interrupt request is raised if interrupts are enabled.

Software reaches the block through a small 8-bit register port. A 16-bit value moves as two bytes through a shared high-byte holding register, so each access is coherent. Reading the low byte snapshots the high byte. Writing the low byte commits both bytes at once. The capture register can also be written, because the timer may use it as its TOP value. While the timer runs in that mode, an input line tells the block to stop capturing. The timer, its prescaler and the comparator lie outside the block and appear only as inputs.

Top module: `icap_unit`

## Requirements
- R1: After reset the capture register is 0, the flag is 0, the control register is 0 and `irq` is low.
- R2: Control register (address 0) bit 0 selects the trigger: 0 = capture pin, 1 = comparator output. With the filter off, a level change first sampled at clock edge N is captured at edge N+2. The capture register then takes the `timer_cnt` value present at edge N+2.
- R3: Control bit 1 selects the polarity: 1 = rising, 0 = falling. Only an edge of the selected polarity captures.
- R4: Control bit 2 enables the filter. A level held for fewer than four synchronized samples produces no capture. A held change is captured at edge N+6, which is exactly four cycles later than the unfiltered case.
- R5: A change of trigger source that changes the selected level is treated as an edge. If its direction matches the polarity, it captures and sets the flag.
- R6: While `top_mode` is high, no capture occurs and the flag is not set by input activity.
- R7: Every capture overwrites the capture register, even if the previous value was never read.
- R8: The status register (address 1) bit 0 is the capture flag. A capture sets it. Writing 1 to that bit clears it, and writing 0 has no effect. If a capture and a clear happen in the same cycle, the capture wins.
- R9: `irq` is high exactly when the flag is set and control bit 3 (interrupt enable) is 1.
- R10: Reading address 2 returns the low byte of the capture register and copies the high byte into the holding register. Reading address 3 returns the holding register.
- R11: Writing address 3 loads the holding register. Writing address 2 sets the capture register to {holding, written byte} at the next edge. If a capture happens in the same cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_cnt | input | 16 | Free-running timer count |
| cap_pin | input | 1 | External capture pin |
| cmp_out | input | 1 | Analog comparator output |
| top_mode | input | 1 | High when the timer uses the capture register as TOP |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, which triggers read side effects |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| cap_q | output | 16 | Capture register, also offered to the timer as TOP |
| irq | output | 1 | Capture interrupt request |

## Verification
The bench measures the exact latency from a pin change to the captured count, both with and without the filter. A filter that added one cycle too many or too few would record a count that is off by one. It sends a three-sample pulse into the filter, which a filter with a short window would wrongly accept. It switches trigger sources with differing levels to confirm that the spurious capture is kept, and it toggles inputs in TOP mode where a missing gate would overwrite the register. It also checks the coherent byte snapshot across an intervening capture. Finally, it lines up a low-byte write with a capture in the same cycle, where the wrong priority would leave the written value in place.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_STAT  = 2'd1,
    A_CAPLO = 2'd2,
    A_CAPHI = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic irq_en;
    logic filt_en;
    logic rise;
    logic src_cmp;
  } ctrl_t;

  // Edge of the wanted polarity between two successive levels.
  function automatic logic edge_hit(logic prev, logic cur, logic rise);
    return (prev != cur) && (cur == rise);
  endfunction

  // All bits of a window agree.
  function automatic logic window_agrees(logic [3:0] w);
    return (&w) || (~|w);
  endfunction
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], din[i]};
    end
    assign dout[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int TAPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout
);
  import icap_pkg::*;

  logic [TAPS-2:0] hist;
  logic [TAPS-1:0] win;
  logic            agree;
  logic            level;

  assign win   = {hist, din};
  assign agree = window_agrees(win);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist  <= '0;
      level <= 1'b0;
    end else begin
      hist <= win[TAPS-2:0];
      if (!en || agree) level <= din;
    end
  end

  assign dout = en ? level : din;

  // R4
  filt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && level != $past(level)) |->
      ($past(din, 1) == level && $past(din, 2) == level &&
       $past(din, 3) == level && $past(din, 4) == level));
endmodule

// File: rtl/icap_edge.sv
module icap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic det,
  input  logic rise,
  input  logic block,
  output logic ev
);
  import icap_pkg::*;

  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= det;
  end

  assign ev = !block && edge_hit(prev, det, rise);

  // R3
  edge_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev |-> (det == rise && $past(det) != det));
endmodule

// File: rtl/icap_regs.sv
module icap_regs #(
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [1:0]          addr,
  input  logic [DW-1:0]       wdata,
  input  logic                cap_ev,
  input  logic [2*DW-1:0]     timer_cnt,
  output icap_pkg::ctrl_t     ctrl,
  output logic [2*DW-1:0]     cap_q,
  output logic                flag_q,
  output logic [DW-1:0]       rdata
);
  import icap_pkg::*;

  logic [DW-1:0] temp_q;
  logic wr_ctrl, wr_stat, wr_lo, wr_hi, rd_lo;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign wr_lo   = wr_en && (addr == A_CAPLO);
  assign wr_hi   = wr_en && (addr == A_CAPHI);
  assign rd_lo   = rd_en && (addr == A_CAPLO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      cap_q  <= '0;
      flag_q <= 1'b0;
      temp_q <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(wdata[3:0]);
      if (cap_ev)     cap_q <= timer_cnt;
      else if (wr_lo) cap_q <= {temp_q, wdata};
      if (cap_ev)                   flag_q <= 1'b1;
      else if (wr_stat && wdata[0]) flag_q <= 1'b0;
      if (wr_hi)      temp_q <= wdata;
      else if (rd_lo) temp_q <= cap_q[2*DW-1:DW];
    end
  end

  always_comb begin
    case (reg_addr_e'(addr))
      A_CTRL:  rdata = {{(DW-4){1'b0}}, ctrl};
      A_STAT:  rdata = {{(DW-1){1'b0}}, flag_q};
      A_CAPLO: rdata = cap_q[DW-1:0];
      default: rdata = temp_q;
    endcase
  end

  // R7
  cap_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> cap_q == $past(timer_cnt));
  // R11
  lo_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !cap_ev) |=> cap_q == {$past(temp_q), $past(wdata)});
  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> flag_q);
  // R8
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[0] && !cap_ev) |=> !flag_q);
  // R10
  temp_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !wr_hi) |=> temp_q == $past(cap_q[2*DW-1:DW]));
endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   timer_cnt,
  input  logic               cap_pin,
  input  logic               cmp_out,
  input  logic               top_mode,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [1:0]         addr,
  input  logic [CNT_W/2-1:0] wdata,
  output logic [CNT_W/2-1:0] rdata,
  output logic [CNT_W-1:0]   cap_q,
  output logic               irq
);
  import icap_pkg::*;

  localparam int DW    = CNT_W / 2;
  localparam int N_SRC = 2;

  ctrl_t            ctrl;
  logic [N_SRC-1:0] raw_src, syn_src;
  logic             sel_lvl, det_lvl, cap_ev, flag_q;

  assign raw_src = {cmp_out, cap_pin};

  icap_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_src), .dout(syn_src)
  );

  assign sel_lvl = ctrl.src_cmp ? syn_src[1] : syn_src[0];

  icap_filter #(.TAPS(FILT_TAPS)) u_filt (
    .clk(clk), .rst_n(rst_n), .en(ctrl.filt_en), .din(sel_lvl), .dout(det_lvl)
  );

  icap_edge u_edge (
    .clk(clk), .rst_n(rst_n), .det(det_lvl), .rise(ctrl.rise),
    .block(top_mode), .ev(cap_ev)
  );

  icap_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cap_ev(cap_ev), .timer_cnt(timer_cnt), .ctrl(ctrl),
    .cap_q(cap_q), .flag_q(flag_q), .rdata(rdata)
  );

  assign irq = flag_q && ctrl.irq_en;

  // R6
  topmode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_mode && !(wr_en && addr == A_CAPLO)) |=> cap_q == $past(cap_q));
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ctrl.irq_en && $past(cap_ev || !ctrl.irq_en)));
endmodule

// File: tb/icap_unit_test.sv
module icap_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tcnt = 16'h1000;
  logic        cap_pin = 1'b0, cmp_out = 1'b0, top_mode = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'd0;
  logic [7:0]  rdata;
  logic [15:0] cap_q;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0, cmp_on = 0;

  always #4 clk = ~clk;
  always @(negedge clk) tcnt <= tcnt + 16'd1;

  icap_unit uut (
    .clk(clk), .rst_n(rst_n), .timer_cnt(tcnt), .cap_pin(cap_pin),
    .cmp_out(cmp_out), .top_mode(top_mode), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cap_q(cap_q), .irq(irq)
  );

  // Behavioural reference model, advanced on each rising edge.
  bit          ms1p, ms2p, ms1c, ms2c, mlevel, mprev, mflag;
  bit          hq[$];
  logic [15:0] mcap;
  logic [7:0]  mtemp;
  logic [3:0]  mctrl;

  always @(posedge clk) begin
    bit sel, det, ev, agr;
    logic [15:0] old_cap;
    if (!rst_n) begin
      ms1p = 0; ms2p = 0; ms1c = 0; ms2c = 0; mlevel = 0; mprev = 0;
      mflag = 0; mcap = 0; mtemp = 0; mctrl = 0;
      hq.delete(); hq.push_back(0); hq.push_back(0); hq.push_back(0);
    end else begin
      sel = mctrl[0] ? ms2c : ms2p;
      det = mctrl[2] ? mlevel : sel;
      ev  = (det != mprev) && (det == mctrl[1]) && !top_mode;
      agr = 1;
      foreach (hq[k]) if (hq[k] != sel) agr = 0;
      if (!mctrl[2] || agr) mlevel = sel;
      hq.push_back(sel);
      void'(hq.pop_front());
      mprev = det;
      ms2p = ms1p; ms1p = cap_pin;
      ms2c = ms1c; ms1c = cmp_out;
      old_cap = mcap;
      if (ev) mcap = tcnt;
      else if (wr_en && addr == 2'd2) mcap = {mtemp, wdata};
      if (ev) mflag = 1;
      else if (wr_en && addr == 2'd1 && wdata[0]) mflag = 0;
      if (wr_en && addr == 2'd3) mtemp = wdata;
      else if (rd_en && addr == 2'd2) mtemp = old_cap[15:8];
      if (wr_en && addr == 2'd0) mctrl = wdata[3:0];
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Cycle compare against the model.
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(cap_q == mcap, "R7 cap_q vs model", cap_q, mcap);
      chk(irq == (mflag && mctrl[3]), "R9 irq vs model", irq, mflag && mctrl[3]);
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); #1;
    addr = a; rd_en = 1'b1;
    #1 chk(rdata == exp, tag, rdata, exp);
    @(negedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic set_pin(input bit v, output logic [15:0] t0);
    @(negedge clk); #1;
    cap_pin = v; t0 = tcnt;
  endtask

  task automatic set_cmp(input bit v);
    @(negedge clk); #1;
    cmp_out = v;
  endtask

  task automatic wait_at(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk); #2;
  endtask

  initial begin
    logic [15:0] t0, c;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    wait_at(1);
    chk(cap_q == 0, "R1 cap_q reset", cap_q, 0);
    chk(irq == 0, "R1 irq reset", irq, 0);
    bus_rd(2'd0, 8'h00, "R1 ctrl reset");
    bus_rd(2'd1, 8'h00, "R1 flag reset");
    cmp_on = 1;

    // R2: rising capture on the pin, interrupt enabled
    bus_wr(2'd0, 8'b1010);
    set_pin(1, t0);
    wait_at(3);
    chk(cap_q == t0 + 16'd2, "R2 unfiltered latency", cap_q, t0 + 16'd2);
    chk(irq == 1, "R9 irq with flag and enable", irq, 1);
    bus_rd(2'd1, 8'h01, "R8 flag set by capture");

    // R8: write 0 no effect, write 1 clears
    bus_wr(2'd1, 8'h00);
    bus_rd(2'd1, 8'h01, "R8 write zero keeps flag");
    bus_wr(2'd1, 8'h01);
    bus_rd(2'd1, 8'h00, "R8 write one clears");

    // R3: polarity
    c = cap_q;
    set_pin(0, t0);
    wait_at(4);
    chk(cap_q == c, "R3 falling ignored in rising mode", cap_q, c);
    bus_wr(2'd0, 8'b1000);
    set_pin(1, t0);
    wait_at(4);
    chk(cap_q == c, "R3 rising ignored in falling mode", cap_q, c);
    set_pin(0, t0);
    wait_at(3);
    chk(cap_q == t0 + 16'd2, "R3 falling captured", cap_q, t0 + 16'd2);
    bus_wr(2'd1, 8'h01);

    // R4: filter
    bus_wr(2'd0, 8'b1110);
    c = cap_q;
    set_pin(1, t0);
    @(negedge clk); @(negedge clk);
    set_pin(0, t0);
    wait_at(8);
    chk(cap_q == c, "R4 short pulse rejected", cap_q, c);
    set_pin(1, t0);
    wait_at(6);
    chk(cap_q == c, "R4 not captured before N+6", cap_q, c);
    wait_at(1);
    chk(cap_q == t0 + 16'd6, "R4 filtered latency", cap_q, t0 + 16'd6);
    bus_wr(2'd1, 8'h01);
    bus_wr(2'd0, 8'b1010);

    // R5: source switch from pin (1) to comparator (0), falling polarity
    bus_wr(2'd0, 8'b1000);
    c = cap_q;
    bus_wr(2'd0, 8'b1001);
    wait_at(2);
    chk(cap_q != c, "R5 source switch captured", cap_q, c);
    bus_rd(2'd1, 8'h01, "R5 source switch sets flag");
    bus_wr(2'd1, 8'h01);

    // R6: TOP mode blocks captures
    @(negedge clk); #1 top_mode = 1'b1;
    c = cap_q;
    set_cmp(1);
    wait_at(4);
    set_cmp(0);
    wait_at(4);
    chk(cap_q == c, "R6 no capture in top mode", cap_q, c);
    bus_rd(2'd1, 8'h00, "R6 flag untouched in top mode");
    @(negedge clk); #1 top_mode = 1'b0;

    // R7: overwrite (switch back to the pin causes a capture too)
    bus_wr(2'd0, 8'b1010);
    set_pin(0, t0);
    wait_at(3);
    set_pin(1, t0);
    wait_at(3);
    chk(cap_q == t0 + 16'd2, "R7 first capture", cap_q, t0 + 16'd2);
    set_pin(0, t0);
    wait_at(3);
    set_pin(1, t0);
    wait_at(3);
    chk(cap_q == t0 + 16'd2, "R7 second capture overwrites", cap_q, t0 + 16'd2);

    // R10: coherent snapshot
    c = cap_q;
    bus_rd(2'd2, c[7:0], "R10 low byte read");
    set_pin(0, t0);
    wait_at(3);
    set_pin(1, t0);
    wait_at(3);
    chk(cap_q == t0 + 16'd2, "R10 new capture after snapshot", cap_q, t0 + 16'd2);
    bus_rd(2'd3, c[15:8], "R10 high byte from snapshot");

    // R11: 16-bit write and collision priority
    bus_wr(2'd3, 8'hAB);
    bus_wr(2'd2, 8'hCD);
    chk(cap_q == 16'hABCD, "R11 two-byte write", cap_q, 16'hABCD);
    bus_rd(2'd2, 8'hCD, "R11 low byte readback");
    bus_rd(2'd3, 8'hAB, "R11 high byte readback");
    set_pin(0, t0);
    wait_at(3);
    set_pin(1, t0);
    @(negedge clk);
    bus_wr(2'd2, 8'h55);
    chk(cap_q == t0 + 16'd2, "R11 capture wins over write", cap_q, t0 + 16'd2);

    // R9: enable gates the request
    bus_wr(2'd0, 8'b0010);
    wait_at(1);
    chk(irq == 0, "R9 irq masked", irq, 0);
    bus_rd(2'd1, 8'h01, "R9 flag still set while masked");
    bus_wr(2'd0, 8'b1010);
    wait_at(1);
    chk(irq == 1, "R9 irq unmasked", irq, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule